// File: doc/BRIEF.md
# I2C Slave with SMBus Quick-Command Detection

This block is a byte-wide I2C slave that can both receive and transmit. It also recognises SMBus quick commands. A quick command is a transfer that carries its single bit of payload in the R/W position of the address byte and never completes a data byte. The block watches already-filtered SCL and SDA levels and detects START and STOP conditions. It compares the upper seven bits of each address byte with its own address and answers by pulling SDA low.

On a write, each received byte is acknowledged only while the local side reports that it is ready. Otherwise the byte is refused with a NACK. On a read, the block stretches the clock after the address acknowledge and raises a data request. It releases SCL once a transmit byte has been written, and then shifts that byte out MSB first.

When a STOP ends a transaction whose last address phase matched, the block pulses a stop interrupt. At the same moment it latches two status bits:
- A quick-command flag, set when no complete data byte moved since the last START.
- A direction bit that copies the R/W bit.

For a read quick command, the local side answers the data request with 0xFF, so the single bit the master clocks back reads 1.

Top module: `i2c_quick_slave`

## Requirements
- R1: An address byte whose upper seven bits differ from `own_addr` is never acknowledged. The block does not drive SDA for the rest of that transaction, and the STOP that ends it produces no stop interrupt.
- R2: An address byte whose upper seven bits equal `own_addr` is always acknowledged by pulling SDA low during the ninth clock, whatever the level of `rx_ready`.
- R3: On a write with `rx_ready`=1, a received data byte is acknowledged, copied to `rx_data` and signalled by a one-cycle pulse on `irq_data_req`.
- R4: On a write with `rx_ready`=0, a received data byte is refused with a NACK (SDA left high during its ninth clock), and `rx_data` keeps its previous value.
- R5: A matched write address followed directly by STOP produces a one-cycle `irq_stop` with `qcmd_flag`=1 and `qcmd_dir`=0. `irq_data_req` stays low during that transaction.
- R6: On a matched read address, after the acknowledge clock, the block holds SCL low (`scl_oe`=1) and keeps `irq_data_req` high until `tx_wr` is pulsed. It then releases SCL and sends the written byte MSB first.
- R7: A matched read address, answered with 0xFF and followed by STOP after a single clocked bit, produces `irq_stop` with `qcmd_flag`=1 and `qcmd_dir`=1. The bit the master reads is 1.
- R8: When a complete data byte was received or sent after the last START, the STOP that follows sets `qcmd_flag`=0. `qcmd_dir` always equals the last matched R/W bit.
- R9: A repeated START restarts address matching. The status latched at STOP reflects only the segment after the last START, and an unmatched last segment gives no stop interrupt.
- R10: After reset, `sda_oe`, `scl_oe`, `irq_data_req`, `irq_stop`, `qcmd_flag`, `qcmd_dir` are 0 and `rx_data` is 0.
- R11: `sda_oe` changes only while SCL is low, so the block never creates a false START or STOP.
- R12: During a read, a master ACK (SDA low in the ninth clock) makes the block stretch SCL and request the next byte again. A master NACK makes it release both lines with no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Filtered SCL line level |
| sda_in | input | 1 | Filtered SDA line level |
| own_addr | input | BYTE_W-1 | Own 7-bit slave address |
| tx_data | input | BYTE_W | Transmit byte |
| tx_wr | input | 1 | Write strobe loading `tx_data` |
| rx_ready | input | 1 | 1 = data bytes are acknowledged |
| sda_oe | output | 1 | 1 = pull SDA low |
| scl_oe | output | 1 | 1 = pull SCL low (read stretch) |
| rx_data | output | BYTE_W | Last accepted received byte |
| irq_data_req | output | 1 | Level while a transmit byte is needed; pulse on a received byte |
| irq_stop | output | 1 | One-cycle pulse at STOP of an addressed transaction |
| qcmd_flag | output | 1 | Last addressed transaction was a quick command |
| qcmd_dir | output | 1 | R/W bit of the last addressed transaction |

## Verification
The bench targets four behaviours:
- Quick write against a one-byte write. A design that set the quick flag from the R/W bit, or at the address ACK instead of at STOP, would report a one-byte write as a quick command.
- Quick read against a full read. A design that failed to stretch, or drove bit 6 first, would return the wrong bits or a 0 where the master expects the 1 of the 0xFF answer.
- Address ACK while not ready. A slave that gated the address ACK by `rx_ready` would NACK the address, and the stop interrupt the scoreboard expects would never arrive.
- Repeated START. A design that kept the first segment's match or byte count would report a stale status, or would interrupt on a transaction that ended addressed to another device.

// File: rtl/i2c_qs_pkg.sv
package i2c_qs_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_AACK,
      S_RX,
      S_RACK,
      S_TWAIT,
      S_TX,
      S_TACK
   } qs_state_e;

endpackage

// File: rtl/i2c_qs_line.sv
module i2c_qs_line #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_val,
   output logic sda_val,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_s, sda_s;
   logic scl_p, sda_p;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl_s = scl_in;
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_r, sda_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_r <= '1;
               sda_r <= '1;
            end else begin
               scl_r[0] <= scl_in;
               sda_r[0] <= sda_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  scl_r[i] <= scl_r[i-1];
                  sda_r[i] <= sda_r[i-1];
               end
            end
         end
         assign scl_s = scl_r[SYNC_STAGES-1];
         assign sda_s = sda_r[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_val   = scl_s;
   assign sda_val   = sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_qs_fsm.sv
module i2c_qs_fsm
   import i2c_qs_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int ADDR_W = BYTE_W - 1,
   localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_val,
   input  logic              sda_val,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_wr,
   input  logic              rx_ready,
   output logic              sda_oe,
   output logic              scl_oe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_stb,
   output logic              seg_match,
   output logic              byte_done,
   output logic              rw_bit
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   qs_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic              mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cnt       <= '0;
         sh        <= '0;
         rw_bit    <= 1'b0;
         seg_match <= 1'b0;
         byte_done <= 1'b0;
         sda_oe    <= 1'b0;
         mack      <= 1'b0;
         rx_data   <= '0;
         rx_stb    <= 1'b0;
      end else begin
         rx_stb <= 1'b0;
         if (start_det) begin
            state     <= S_ADDR;
            cnt       <= '0;
            seg_match <= 1'b0;
            byte_done <= 1'b0;
            sda_oe    <= 1'b0;
         end else if (stop_det) begin
            state     <= S_IDLE;
            cnt       <= '0;
            seg_match <= 1'b0;
            sda_oe    <= 1'b0;
         end else begin
            case (state)
               S_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_val};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     if (sh[BYTE_W-1:1] == own_addr) begin
                        seg_match <= 1'b1;
                        rw_bit    <= sh[0];
                        sda_oe    <= 1'b1;
                        state     <= S_AACK;
                     end else begin
                        state <= S_IDLE;
                     end
                  end
               end
               S_AACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= rw_bit ? S_TWAIT : S_RX;
                  end
               end
               S_RX: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_val};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     byte_done <= 1'b1;
                     if (rx_ready) begin
                        rx_data <= sh;
                        rx_stb  <= 1'b1;
                        sda_oe  <= 1'b1;
                     end
                     state <= S_RACK;
                  end
               end
               S_RACK: begin
                  if (scl_fall) begin
                     state  <= sda_oe ? S_RX : S_IDLE;
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                  end
               end
               S_TWAIT: begin
                  if (tx_wr) begin
                     sh     <= tx_data;
                     sda_oe <= ~tx_data[BYTE_W-1];
                     cnt    <= '0;
                     state  <= S_TX;
                  end
               end
               S_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == FULL) begin
                        sda_oe    <= 1'b0;
                        byte_done <= 1'b1;
                        state     <= S_TACK;
                     end else begin
                        sda_oe <= ~sh[BYTE_W-2];
                        sh     <= sh << 1;
                     end
                  end
               end
               S_TACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_val;
                  end else if (scl_fall) begin
                     state <= mack ? S_TWAIT : S_IDLE;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   assign scl_oe = (state == S_TWAIT);

   AST_ADDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_ADDR && scl_fall && cnt == FULL && sh[BYTE_W-1:1] == own_addr
       && !start_det && !stop_det) |=> (sda_oe && state == S_AACK)); // R2

   AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RX && scl_fall && cnt == FULL && !rx_ready
       && !start_det && !stop_det) |=> !sda_oe); // R4

   AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && tx_wr && !start_det && !stop_det) |=> !scl_oe); // R6

   AST_SDA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_val && $past(scl_val) && !$past(tx_wr) && !$past(start_det)
       && !$past(stop_det)) |-> $stable(sda_oe)); // R11

endmodule

// File: rtl/i2c_qs_status.sv
module i2c_qs_status (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_det,
   input  logic seg_match,
   input  logic byte_done,
   input  logic rw_bit,
   input  logic tx_need,
   input  logic rx_stb,
   output logic irq_stop,
   output logic qcmd_flag,
   output logic qcmd_dir,
   output logic irq_data_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_stop  <= 1'b0;
         qcmd_flag <= 1'b0;
         qcmd_dir  <= 1'b0;
      end else begin
         irq_stop <= stop_det & seg_match;
         if (stop_det && seg_match) begin
            qcmd_flag <= ~byte_done;
            qcmd_dir  <= rw_bit;
         end
      end
   end

   assign irq_data_req = tx_need | rx_stb;

   AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_stop |=> !irq_stop); // R5

   AST_QCMD_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qcmd_flag) |-> $past(stop_det && seg_match)); // R7

   AST_DIR_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(qcmd_dir) |-> $past(stop_det && seg_match)); // R8

endmodule

// File: rtl/i2c_quick_slave.sv
module i2c_quick_slave #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = BYTE_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_wr,
   input  logic              rx_ready,
   output logic              sda_oe,
   output logic              scl_oe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              irq_data_req,
   output logic              irq_stop,
   output logic              qcmd_flag,
   output logic              qcmd_dir
);

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("i2c_quick_slave: BYTE_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("i2c_quick_slave: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic scl_val, sda_val, scl_rise, scl_fall, start_det, stop_det;
   logic rx_stb, seg_match, byte_done, rw_bit;

   i2c_qs_line #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_val   (scl_val),
      .sda_val   (sda_val),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_qs_fsm #(
      .BYTE_W (BYTE_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_val   (scl_val),
      .sda_val   (sda_val),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .own_addr  (own_addr),
      .tx_data   (tx_data),
      .tx_wr     (tx_wr),
      .rx_ready  (rx_ready),
      .sda_oe    (sda_oe),
      .scl_oe    (scl_oe),
      .rx_data   (rx_data),
      .rx_stb    (rx_stb),
      .seg_match (seg_match),
      .byte_done (byte_done),
      .rw_bit    (rw_bit)
   );

   i2c_qs_status u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_det     (stop_det),
      .seg_match    (seg_match),
      .byte_done    (byte_done),
      .rw_bit       (rw_bit),
      .tx_need      (scl_oe),
      .rx_stb       (rx_stb),
      .irq_stop     (irq_stop),
      .qcmd_flag    (qcmd_flag),
      .qcmd_dir     (qcmd_dir),
      .irq_data_req (irq_data_req)
   );

endmodule

// File: tb/sim_i2c_quick_slave.sv
module sim_i2c_quick_slave;

   localparam int CLK_P = 10;
   localparam int QTR   = 8;
   localparam logic [6:0] OWN = 7'h3A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [7:0] tx_data = 8'h00;
   logic tx_wr = 1'b0, rx_ready = 1'b1;
   logic sda_oe, scl_oe, irq_data_req, irq_stop, qcmd_flag, qcmd_dir;
   logic [7:0] rx_data;
   logic scl_line, sda_line;

   assign scl_line = scl_m & ~scl_oe;
   assign sda_line = sda_m & ~sda_oe;

   i2c_quick_slave u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_in       (scl_line),
      .sda_in       (sda_line),
      .own_addr     (OWN),
      .tx_data      (tx_data),
      .tx_wr        (tx_wr),
      .rx_ready     (rx_ready),
      .sda_oe       (sda_oe),
      .scl_oe       (scl_oe),
      .rx_data      (rx_data),
      .irq_data_req (irq_data_req),
      .irq_stop     (irq_stop),
      .qcmd_flag    (qcmd_flag),
      .qcmd_dir     (qcmd_dir)
   );

   int checks = 0, fails = 0;
   int stop_cnt = 0, req_rise = 0, quiet_viol = 0;

   typedef struct {
      bit    flag;
      bit    dir;
      string tag;
   } stop_t;
   stop_t sq[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input bit f, input bit d, input string t);
      sq.push_back('{f, d, t});
   endtask

   // monitor: pops expected stop results and watches line discipline
   initial begin : mon
      logic ps, po, pr;
      ps = 1'b1; po = 1'b0; pr = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (irq_stop) begin
               stop_cnt++;
               if (sq.size() == 0) begin
                  checks++;
                  fails++;
                  $display("FAIL R1 unexpected stop interrupt actual=1 expected=0");
               end else begin
                  stop_t e;
                  e = sq.pop_front();
                  chk(qcmd_flag == e.flag, {e.tag, " qcmd_flag"}, qcmd_flag, e.flag);
                  chk(qcmd_dir == e.dir, {e.tag, " qcmd_dir"}, qcmd_dir, e.dir);
               end
            end
            if (irq_data_req && !pr) req_rise++;
            if (scl_line && ps && sda_oe != po) quiet_viol++;
         end
         ps = scl_line;
         po = sda_oe;
         pr = irq_data_req;
      end
   end

   task automatic wq();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic scl_up();
      scl_m = 1'b1;
      do @(negedge clk); while (!scl_line);
      wq();
   endtask

   task automatic m_start();
      sda_m = 1'b1; wq();
      scl_up();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic m_stop();
      sda_m = 1'b0; wq();
      scl_up();
      sda_m = 1'b1; wq();
   endtask

   task automatic m_bit(input bit b);
      sda_m = b; wq();
      scl_up();
      scl_m = 1'b0; wq();
   endtask

   task automatic m_rbit(output bit b);
      sda_m = 1'b1; wq();
      scl_up();
      b = sda_line;
      scl_m = 1'b0; wq();
   endtask

   task automatic m_wbyte(input logic [7:0] v, output bit nack);
      for (int i = 7; i >= 0; i--) m_bit(v[i]);
      m_rbit(nack);
   endtask

   task automatic m_rbyte(output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         m_rbit(b);
         v[i] = b;
      end
   endtask

   task automatic load(input logic [7:0] v);
      @(negedge clk);
      tx_data = v;
      tx_wr   = 1'b1;
      @(negedge clk);
      tx_wr   = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin : drv
      bit nk, b;
      int sc, rr;
      logic [7:0] v;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R10 reset state
      chk({sda_oe, scl_oe, irq_data_req, irq_stop, qcmd_flag, qcmd_dir} == 6'b0,
          "R10 outputs after reset",
          {sda_oe, scl_oe, irq_data_req, irq_stop, qcmd_flag, qcmd_dir}, 0);
      chk(rx_data == 8'h00, "R10 rx_data after reset", rx_data, 0);

      // quick write
      rr = req_rise;
      m_start();
      m_wbyte({OWN, 1'b0}, nk);
      chk(nk == 1'b0, "R2 address ack on quick write", nk, 0);
      push(1'b1, 1'b0, "R5");
      m_stop();
      chk(sq.size() == 0, "R5 stop interrupt seen", sq.size(), 0);
      chk(req_rise == rr, "R5 no data request", req_rise - rr, 0);

      // one-byte write, ready
      rx_ready = 1'b1;
      rr = req_rise;
      m_start();
      m_wbyte({OWN, 1'b0}, nk);
      m_wbyte(8'hA5, nk);
      chk(nk == 1'b0, "R3 data byte acked", nk, 0);
      chk(rx_data == 8'hA5, "R3 rx_data", rx_data, 8'hA5);
      chk(req_rise - rr == 1, "R3 data pulse count", req_rise - rr, 1);
      push(1'b0, 1'b0, "R8");
      m_stop();
      chk(sq.size() == 0, "R8 stop after written byte", sq.size(), 0);

      // not ready: address still acked, data refused
      rx_ready = 1'b0;
      m_start();
      m_wbyte({OWN, 1'b0}, nk);
      chk(nk == 1'b0, "R2 address ack while not ready", nk, 0);
      m_wbyte(8'h5C, nk);
      chk(nk == 1'b1, "R4 data nack while not ready", nk, 1);
      chk(rx_data == 8'hA5, "R4 rx_data kept", rx_data, 8'hA5);
      push(1'b0, 1'b0, "R4");
      m_stop();
      rx_ready = 1'b1;

      // address mismatch
      sc = stop_cnt;
      m_start();
      m_wbyte({7'h3B, 1'b0}, nk);
      chk(nk == 1'b1, "R1 foreign address not acked", nk, 1);
      m_wbyte(8'h00, nk);
      chk(nk == 1'b1, "R1 foreign data not acked", nk, 1);
      m_stop();
      chk(stop_cnt == sc, "R1 no stop interrupt", stop_cnt - sc, 0);

      // quick read
      m_start();
      m_wbyte({OWN, 1'b1}, nk);
      chk(nk == 1'b0, "R2 read address acked", nk, 0);
      chk(scl_oe && irq_data_req, "R6 stretch and request", {scl_oe, irq_data_req}, 3);
      repeat (20) @(negedge clk);
      chk(scl_oe && irq_data_req, "R6 stretch held", {scl_oe, irq_data_req}, 3);
      load(8'hFF);
      @(negedge clk);
      chk(!scl_oe, "R6 clock released after load", scl_oe, 0);
      m_rbit(b);
      chk(b == 1'b1, "R7 quick read bit", b, 1);
      push(1'b1, 1'b1, "R7");
      m_stop();
      chk(sq.size() == 0, "R7 stop interrupt seen", sq.size(), 0);

      // two-byte read
      m_start();
      m_wbyte({OWN, 1'b1}, nk);
      load(8'hC3);
      m_rbyte(v);
      chk(v == 8'hC3, "R6 first read byte MSB first", v, 8'hC3);
      m_bit(1'b0);
      chk(scl_oe && irq_data_req, "R12 request after master ack", {scl_oe, irq_data_req}, 3);
      load(8'h5A);
      m_rbyte(v);
      chk(v == 8'h5A, "R6 second read byte", v, 8'h5A);
      m_bit(1'b1);
      wq();
      chk({scl_oe, sda_oe, irq_data_req} == 3'b0, "R12 release after master nack",
          {scl_oe, sda_oe, irq_data_req}, 0);
      push(1'b0, 1'b1, "R8");
      m_stop();

      // repeated start, matched segment last
      m_start();
      m_wbyte({OWN, 1'b0}, nk);
      m_wbyte(8'h11, nk);
      m_start();
      m_wbyte({OWN, 1'b0}, nk);
      chk(nk == 1'b0, "R9 readdress acked", nk, 0);
      push(1'b1, 1'b0, "R9");
      m_stop();
      chk(sq.size() == 0, "R9 quick after repeated start", sq.size(), 0);

      // repeated start to a foreign address
      sc = stop_cnt;
      m_start();
      m_wbyte({OWN, 1'b0}, nk);
      m_wbyte(8'h22, nk);
      m_start();
      m_wbyte({7'h12, 1'b0}, nk);
      chk(nk == 1'b1, "R9 foreign second segment nacked", nk, 1);
      m_stop();
      chk(stop_cnt == sc, "R9 no interrupt for foreign segment", stop_cnt - sc, 0);

      chk(quiet_viol == 0, "R11 SDA moved while SCL high", quiet_viol, 0);

      summary();
      $finish;
   end

endmodule